// File: doc/BRIEF.md
# Keypad Wake Interrupt Detector

This block watches four key-scan lines and raises a single interrupt request when a key is pressed. A press pulls its line low. Each raw pin passes through a two-stage synchronizer. Any line whose direction bit selects output is forced high. The remaining lines are then ANDed into one combined level. A high-to-low change of that combined level counts as a key event.

A key event sets a sticky pending flag. It also produces a one-cycle wake pulse that can bring a sleeping core out of its low-power state. Software clears the pending flag with a write-one-to-clear strobe, or the CPU clears it by acknowledging the interrupt. The request goes to the CPU only while the interrupt priority field is nonzero. A zero priority still lets the pending flag be polled.

A global disable bit blocks key events. It also forces the port readback of all four lines to the inactive high level.

Top module: `kbd_wake_irq`

## Requirements
- R1: After reset, irq_pend_o, irq_req_o and wake_o are 0, and key_rd_o reads 4'b1111 until synchronized pin levels arrive.
- R2: A falling edge on one input-mode line, with the other participating lines high, sets irq_pend_o and raises wake_o on the third rising clock edge after the pin changes. wake_o is high for exactly one cycle.
- R3: Rising edges and steady levels on the key lines never set irq_pend_o or raise wake_o.
- R4: A line whose key_dir_in_i bit is 0 (output mode) is treated as high. A falling edge on it creates no event, and a low level on it does not mask the other lines.
- R5: While any participating line is held low, falling edges on the other lines create no event.
- R6: While key_irq_dis_i is 1, no key event sets irq_pend_o or raises wake_o, whatever irq_prio_i holds.
- R7: key_rd_o[i] returns the synchronized pin level two rising edges after the pin changes, for line i in input mode with key_irq_dis_i at 0. In every other case it returns 1.
- R8: irq_pend_o stays set until a cycle with pend_clr_i or irq_ack_i high. A key event in the same cycle as a clear leaves the flag set.
- R9: irq_req_o equals irq_pend_o while irq_prio_i is nonzero and is 0 while irq_prio_i is 0. A zero priority does not stop irq_pend_o from being set.
- R10: Each of the four lines, key_pin_i[0] through key_pin_i[3], can produce a key event on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_pin_i | input | 4 | Raw key line levels; low means pressed |
| key_dir_in_i | input | 4 | Per-line direction; 1 selects input |
| key_irq_dis_i | input | 1 | Global key-interrupt and readback disable |
| irq_prio_i | input | 3 | Interrupt priority; 0 keeps the request from the CPU |
| pend_clr_i | input | 1 | Write-one-to-clear strobe for the pending flag |
| irq_ack_i | input | 1 | Interrupt acknowledge; clears the pending flag |
| irq_pend_o | output | 1 | Sticky pending flag |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| wake_o | output | 1 | One-cycle wake pulse on each key event |
| key_rd_o | output | 4 | Gated port readback of the key lines |

## Verification
The bench holds one key low and then drops a second key. A design that edge-detects each line separately instead of detecting edges on the ANDed level would report the second key.

It drives a low on a line set to output mode, and checks that this line neither fires nor hides a later press on another line. A design that forgets to force output lines high would fail one of those two checks.

It lines up a clear strobe with the very cycle of a new key event. A design that lets the clear win would lose the event.

It also checks three more cases:
- The priority field at zero must still set the pending flag. A design that gates the flag on the priority would break polling.
- With the disable bit set, the readback must stay high even for input-mode lines.
- The wake pulse must last exactly one cycle. A design that derives it from the level rather than the edge would hold it high.

// File: rtl/kbd_wake_pkg.sv
package kbd_wake_pkg;
  localparam int unsigned KEY_LINES = 4;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned PRIO_BITS = 3;

  typedef struct packed {
    logic pend;
    logic wake;
  } kbd_evt_state_t;
endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // reset to idle-high so no false edge at power-up
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '1;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '1;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/kbd_combine_edge.sv
module kbd_combine_edge #(
  parameter int unsigned NUM_KEYS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_KEYS-1:0] lvl_i,
  input  logic [NUM_KEYS-1:0] dir_in_i,
  input  logic                dis_i,
  output logic                evt_o,
  output logic [NUM_KEYS-1:0] rd_o
);
  logic [NUM_KEYS-1:0] gated;
  logic                comb_lvl;
  logic                comb_q;

  // output-mode lines forced high before the AND
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_gate
    assign gated[k] = lvl_i[k] | ~dir_in_i[k];
    assign rd_o[k]  = gated[k] | dis_i;
  end

  assign comb_lvl = &gated;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) comb_q <= 1'b1;
    else         comb_q <= comb_lvl;
  end

  assign evt_o = comb_q & ~comb_lvl & ~dis_i;
endmodule

// File: rtl/kbd_pend_ctrl.sv
module kbd_pend_ctrl
  import kbd_wake_pkg::*;
#(
  parameter int unsigned PRIO_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic              clr_i,
  input  logic              ack_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic              pend_o,
  output logic              wake_o,
  output logic              req_o
);
  kbd_evt_state_t st_q, st_d;

  always_comb begin
    st_d      = st_q;
    st_d.wake = evt_i;
    if (clr_i || ack_i) st_d.pend = 1'b0;
    if (evt_i)          st_d.pend = 1'b1; // new event beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign pend_o = st_q.pend;
  assign wake_o = st_q.wake;
  assign req_o  = st_q.pend & (|prio_i);
endmodule

// File: rtl/kbd_wake_irq.sv
module kbd_wake_irq
  import kbd_wake_pkg::*;
#(
  parameter int unsigned NUM_KEYS = KEY_LINES,
  parameter int unsigned SYNC_N   = SYNC_DEPTH,
  parameter int unsigned PRIO_W   = PRIO_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_KEYS-1:0] key_pin_i,
  input  logic [NUM_KEYS-1:0] key_dir_in_i,
  input  logic                key_irq_dis_i,
  input  logic [PRIO_W-1:0]   irq_prio_i,
  input  logic                pend_clr_i,
  input  logic                irq_ack_i,
  output logic                irq_pend_o,
  output logic                irq_req_o,
  output logic                wake_o,
  output logic [NUM_KEYS-1:0] key_rd_o
);
  logic [NUM_KEYS-1:0] key_sync;
  logic                key_evt;

  kbd_sync #(.WIDTH(NUM_KEYS), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (key_pin_i),
    .q_o   (key_sync)
  );

  kbd_combine_edge #(.NUM_KEYS(NUM_KEYS)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (key_sync),
    .dir_in_i(key_dir_in_i),
    .dis_i   (key_irq_dis_i),
    .evt_o   (key_evt),
    .rd_o    (key_rd_o)
  );

  kbd_pend_ctrl #(.PRIO_W(PRIO_W)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (key_evt),
    .clr_i (pend_clr_i),
    .ack_i (irq_ack_i),
    .prio_i(irq_prio_i),
    .pend_o(irq_pend_o),
    .wake_o(wake_o),
    .req_o (irq_req_o)
  );
endmodule

// File: rtl/kbd_wake_irq_chk.sv
module kbd_wake_irq_chk #(
  parameter int unsigned NUM_KEYS = 4,
  parameter int unsigned PRIO_W   = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                key_irq_dis_i,
  input logic [PRIO_W-1:0]   irq_prio_i,
  input logic                pend_clr_i,
  input logic                irq_ack_i,
  input logic                irq_pend_o,
  input logic                irq_req_o,
  input logic                wake_o,
  input logic [NUM_KEYS-1:0] key_rd_o
);
  AST_WAKE_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> irq_pend_o); // R2
  AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R2
  AST_PEND_RISE_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_pend_o) |-> wake_o); // R2
  AST_DIS_NO_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_irq_dis_i |=> !wake_o); // R6
  AST_DIS_RD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_irq_dis_i |-> (&key_rd_o)); // R7
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pend_o && !pend_clr_i && !irq_ack_i) |=> irq_pend_o); // R8
  AST_REQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_pend_o && (irq_prio_i != '0))); // R9
endmodule

bind kbd_wake_irq kbd_wake_irq_chk #(.NUM_KEYS(NUM_KEYS), .PRIO_W(PRIO_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .key_irq_dis_i(key_irq_dis_i),
  .irq_prio_i   (irq_prio_i),
  .pend_clr_i   (pend_clr_i),
  .irq_ack_i    (irq_ack_i),
  .irq_pend_o   (irq_pend_o),
  .irq_req_o    (irq_req_o),
  .wake_o       (wake_o),
  .key_rd_o     (key_rd_o)
);

// File: tb/kbd_wake_irq_tb_top.sv
module kbd_wake_irq_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] key_pin_i = 4'hF;
  logic [3:0] key_dir_in_i = 4'hF;
  logic       key_irq_dis_i = 1'b0;
  logic [2:0] irq_prio_i = 3'd0;
  logic       pend_clr_i = 1'b0;
  logic       irq_ack_i = 1'b0;
  logic       irq_pend_o, irq_req_o, wake_o;
  logic [3:0] key_rd_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  kbd_wake_irq dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clear_pend();
    @(negedge clk_i) pend_clr_i = 1'b1;
    @(negedge clk_i) pend_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 pend", irq_pend_o, 0);
    check("R1 req", irq_req_o, 0);
    check("R1 wake", wake_o, 0);
    check("R1 rd", key_rd_o, 4'hF);
  endtask

  task automatic t_each_line();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i) key_pin_i[i] = 1'b0;
      cycles(2);
      check("R2 no early pend", irq_pend_o, 0);
      cycles(1);
      check("R10 pend on line", irq_pend_o, 1);
      check("R2 wake", wake_o, 1);
      cycles(1);
      check("R2 wake one cycle", wake_o, 0);
      key_pin_i[i] = 1'b1;
      cycles(4);
      clear_pend();
      check("R8 cleared", irq_pend_o, 0);
    end
  endtask

  task automatic t_rise_steady();
    @(negedge clk_i) key_pin_i = 4'hF;
    cycles(6);
    check("R3 steady high", irq_pend_o, 0);
    key_pin_i[1] = 1'b0;
    cycles(5);
    clear_pend();
    key_pin_i[1] = 1'b1;
    cycles(5);
    check("R3 rising pend", irq_pend_o, 0);
    check("R3 rising wake", wake_o, 0);
  endtask

  task automatic t_dir_output();
    @(negedge clk_i) key_dir_in_i = 4'b1011;
    key_pin_i[2] = 1'b0;
    cycles(5);
    check("R4 output line no event", irq_pend_o, 0);
    check("R7 output line rd", key_rd_o[2], 1);
    key_pin_i[0] = 1'b0;
    cycles(3);
    check("R4 output low no mask", irq_pend_o, 1);
    key_pin_i = 4'hF;
    cycles(4);
    key_dir_in_i = 4'hF;
    clear_pend();
  endtask

  task automatic t_and_mask();
    @(negedge clk_i) key_pin_i[0] = 1'b0;
    cycles(4);
    clear_pend();
    key_pin_i[1] = 1'b0;
    cycles(5);
    check("R5 masked by held line", irq_pend_o, 0);
    check("R5 masked wake", wake_o, 0);
    key_pin_i = 4'hF;
    cycles(4);
    check("R3 release both", irq_pend_o, 0);
    key_pin_i[1] = 1'b0;
    cycles(3);
    check("R5 unmasked again", irq_pend_o, 1);
    key_pin_i = 4'hF;
    cycles(4);
    clear_pend();
  endtask

  task automatic t_disable();
    @(negedge clk_i) key_irq_dis_i = 1'b1;
    irq_prio_i = 3'd5;
    key_pin_i[3] = 1'b0;
    cycles(5);
    check("R6 dis no pend", irq_pend_o, 0);
    check("R6 dis no req", irq_req_o, 0);
    check("R7 dis rd high", key_rd_o, 4'hF);
    key_pin_i = 4'hF;
    cycles(4);
    key_irq_dis_i = 1'b0;
    irq_prio_i = 3'd0;
    cycles(1);
  endtask

  task automatic t_readback();
    @(negedge clk_i) key_pin_i = 4'b1010;
    cycles(1);
    check("R7 not yet", key_rd_o, 4'hF);
    cycles(1);
    check("R7 sync level", key_rd_o, 4'b1010);
    key_dir_in_i = 4'b1110;
    #1 check("R7 output line high", key_rd_o, 4'b1011);
    key_pin_i = 4'hF;
    cycles(4);
    key_dir_in_i = 4'hF;
    clear_pend();
  endtask

  task automatic t_set_wins();
    @(negedge clk_i) key_pin_i[2] = 1'b0;
    cycles(2);
    pend_clr_i = 1'b1;
    cycles(1);
    pend_clr_i = 1'b0;
    check("R8 set beats clear", irq_pend_o, 1);
    cycles(3);
    check("R8 sticky", irq_pend_o, 1);
    key_pin_i = 4'hF;
    cycles(4);
    irq_ack_i = 1'b1;
    cycles(1);
    irq_ack_i = 1'b0;
    check("R8 ack clears", irq_pend_o, 0);
  endtask

  task automatic t_prio();
    @(negedge clk_i) irq_prio_i = 3'd0;
    key_pin_i[3] = 1'b0;
    cycles(3);
    check("R9 pend with prio 0", irq_pend_o, 1);
    check("R9 no req prio 0", irq_req_o, 0);
    irq_prio_i = 3'd3;
    #1 check("R9 req prio 3", irq_req_o, 1);
    key_pin_i = 4'hF;
    cycles(4);
    irq_ack_i = 1'b1;
    cycles(1);
    irq_ack_i = 1'b0;
    check("R9 req drops", irq_req_o, 0);
    irq_prio_i = 3'd0;
  endtask

  initial begin
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_each_line();
    t_rise_steady();
    t_dir_output();
    t_and_mask();
    t_disable();
    t_readback();
    t_set_wins();
    t_prio();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule